// File: doc/BRIEF.md
# Per-Core Thread Message Unit

This unit sits next to one processor core and carries short messages between software threads without going through the memory system. The core issues one of five commands over a single request/done handshake: send, peek, receive, enable the arrival interrupt, or disable it. A send names a destination thread and a word count of zero to six. The unit looks up the core that hosts that thread in a small mapping table, copies the message into a send buffer and releases the core at once. It then hands the message to the network port. The buffer entry stays occupied until the network returns an acknowledgement that carries the same tag.

Messages from the network enter a receive queue. The core can inspect the head of the queue without waiting, or it can dequeue the head. A dequeue stalls the core while the queue is empty. When the interrupt is enabled, each accepted arrival raises a one-cycle interrupt pulse. The mapping table is loaded through a write port.

Top module: `msg_unit`

## Requirements
- R1: A send (op code 0) to a mapped thread with a length of 0 to 6 completes (`cmd_done` high, `cmd_err` low) in the cycle it is presented when the send buffer has a free entry. It then appears on the network output with the mapped core ID, the length, the data words below the length, and `self_tid` as the source.
- R2: A send with an unmapped thread ID, a send with a length above 6, and any op code above 4 each complete in the cycle presented with `cmd_err` high, and no message reaches the network output.
- R3: Each send occupies the lowest-numbered free buffer entry, and that index is its network tag. The entry stays occupied until an acknowledgement with that tag is seen. While all 16 entries are occupied, a send holds `cmd_done` low. An acknowledgement lets the stalled send complete in the next cycle.
- R4: Messages leave in the order they were sent. While `net_tx_valid` is high and `net_tx_ready` is low, the offered message and its tag hold steady.
- R5: A peek (op code 1) completes in the cycle it is presented, whether or not the queue has messages. It reports `rsp_empty`. When the queue has a message, it also reports the source thread and length of the head message, and it does not remove that message.
- R6: A receive (op code 2) returns the head message (source, length, data) in arrival order and removes it. It holds `cmd_done` low while the queue is empty.
- R7: `net_rx_ready` is low exactly while the queue holds 16 messages. A message offered while the queue is full is taken once space frees, and no message is lost.
- R8: After enable (op code 3), each accepted arrival drives `irq` high for exactly the following cycle. After disable (op code 4), arrivals are still queued but `irq` stays low. Both commands complete in one cycle.
- R9: After reset, `irq` is low, the interrupt is disabled, `net_tx_valid` is low, `net_rx_ready` is high, the queue is empty, and no table entry is valid.
- R10: A table write with the valid bit set maps a thread to a core. A write with the valid bit clear removes the mapping, and later sends to that thread fail as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| self_tid | input | TID_W | Thread ID placed as source on outgoing messages |
| cmd_valid | input | 1 | Command request, held until done |
| cmd_op | input | 3 | 0 send, 1 peek, 2 receive, 3 irq enable, 4 irq disable |
| cmd_len | input | LEN_W | Send word count |
| cmd_tid | input | TID_W | Send destination thread |
| cmd_data | input | MAX_WORDS*DATA_W | Send data, word 0 in the low bits |
| cmd_done | output | 1 | Command completes this cycle |
| cmd_err | output | 1 | Completed command was rejected |
| rsp_empty | output | 1 | Receive queue empty |
| rsp_src_tid | output | TID_W | Head message source |
| rsp_len | output | LEN_W | Head message length |
| rsp_data | output | MAX_WORDS*DATA_W | Head message data |
| irq | output | 1 | Arrival interrupt pulse |
| tbl_wr_en | input | 1 | Mapping table write |
| tbl_wr_idx | input | log2(XLT_DEPTH) | Table entry index |
| tbl_wr_vld | input | 1 | Entry valid bit written |
| tbl_wr_tid | input | TID_W | Thread ID written |
| tbl_wr_cid | input | CID_W | Core ID written |
| net_tx_valid | output | 1 | Outgoing message offered |
| net_tx_ready | input | 1 | Network takes the offered message |
| net_tx_tag | output | log2(SBUF_DEPTH) | Buffer tag for the acknowledgement |
| net_tx_cid | output | CID_W | Destination core |
| net_tx_src_tid | output | TID_W | Source thread |
| net_tx_len | output | LEN_W | Word count |
| net_tx_data | output | MAX_WORDS*DATA_W | Data words |
| net_ack_valid | input | 1 | Acknowledgement arrives |
| net_ack_tag | input | log2(SBUF_DEPTH) | Tag being acknowledged |
| net_rx_valid | input | 1 | Incoming message offered |
| net_rx_ready | output | 1 | Unit accepts incoming message |
| net_rx_src_tid | input | TID_W | Incoming source thread |
| net_rx_len | input | LEN_W | Incoming word count |
| net_rx_data | input | MAX_WORDS*DATA_W | Incoming data |

## Verification
Two pairs of functions can fall in the same cycle. An arrival from the network can meet a receive dequeue, and an acknowledgement can meet a send that is waiting for buffer space. The bench holds a receive command and an incoming message in the same cycle. It then checks that the returned message is the old head, that the newcomer lands at the tail and raises the interrupt, and that a full drain yields exactly the expected count. It also holds a send against a full buffer, releases it with a single acknowledgement, and checks both the cycle in which the send completes and the tag the send reuses. Random mixes of all five commands with acknowledgements and arrivals then run against a bench model of the queue and the buffer occupancy.

// File: rtl/msg_unit_pkg.sv
package msg_unit_pkg;
  typedef enum logic [2:0] {
    OP_SEND = 3'd0,
    OP_PEEK = 3'd1,
    OP_RECV = 3'd2,
    OP_IEN  = 3'd3,
    OP_IDIS = 3'd4
  } cmd_op_e;
endpackage

// File: rtl/msg_fifo.sv
module msg_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  // R7
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R6
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R6
  fifo_pushpop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(cnt_q));
endmodule

// File: rtl/msg_xlt.sv
module msg_xlt #(
  parameter int TID_W = 8,
  parameter int CID_W = 6,
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  logic [TID_W-1:0] wr_tid,
  input  logic [CID_W-1:0] wr_cid,
  input  logic [TID_W-1:0] lk_tid,
  output logic             lk_hit,
  output logic [CID_W-1:0] lk_cid
);
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [TID_W-1:0] tid_q [DEPTH];
  logic [CID_W-1:0] cid_q [DEPTH];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = wr_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tid_q[wr_idx] <= wr_tid;
      cid_q[wr_idx] <= wr_cid;
    end
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_cid = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i] && tid_q[i] == lk_tid) begin
        lk_hit = 1'b1;
        lk_cid = cid_q[i];
      end
    end
  end

  // R10
  xlt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_vld) |=> !vld_q[$past(wr_idx)]);
endmodule

// File: rtl/msg_sbuf.sv
module msg_sbuf #(
  parameter int PW    = 64,
  parameter int DEPTH = 16,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [PW-1:0]    alloc_pl,
  output logic             full,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [TAG_W-1:0] tx_tag,
  output logic [PW-1:0]    tx_pl,
  input  logic             ack_valid,
  input  logic [TAG_W-1:0] ack_tag
);
  logic [DEPTH-1:0] used_q, used_d;
  logic [PW-1:0]    pl_mem [DEPTH];
  logic [TAG_W-1:0] free_idx;
  logic             txq_empty, txq_full, tx_fire;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!used_q[i]) free_idx = TAG_W'(i);
    end
  end

  assign full    = &used_q;
  assign tx_fire = tx_valid && tx_ready;

  always_comb begin
    used_d = used_q;
    if (alloc)     used_d[free_idx] = 1'b1;
    if (ack_valid) used_d[ack_tag]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_d;
  end

  always_ff @(posedge clk) begin
    if (alloc) pl_mem[free_idx] <= alloc_pl;
  end

  msg_fifo #(.W(TAG_W), .DEPTH(DEPTH)) order_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (alloc),
    .pop   (tx_fire),
    .wdata (free_idx),
    .rdata (tx_tag),
    .empty (txq_empty),
    .full  (txq_full)
  );

  assign tx_valid = !txq_empty;
  assign tx_pl    = pl_mem[tx_tag];

  // R3
  sbuf_alloc_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (!full && !txq_full));
  // R3
  sbuf_ack_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> used_q[ack_tag]);
  // R3
  sbuf_alloc_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> used_q[$past(free_idx)]);
  // R4
  sbuf_tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_tag)));
endmodule

// File: rtl/msg_unit.sv
module msg_unit
  import msg_unit_pkg::*;
#(
  parameter int TID_W      = 8,
  parameter int CID_W      = 6,
  parameter int DATA_W     = 32,
  parameter int MAX_WORDS  = 6,
  parameter int RXQ_DEPTH  = 16,
  parameter int SBUF_DEPTH = 16,
  parameter int XLT_DEPTH  = 16,
  localparam int LEN_W  = $clog2(MAX_WORDS + 1),
  localparam int PW     = MAX_WORDS * DATA_W,
  localparam int TAG_W  = (SBUF_DEPTH > 1) ? $clog2(SBUF_DEPTH) : 1,
  localparam int XIDX_W = (XLT_DEPTH > 1) ? $clog2(XLT_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TID_W-1:0]  self_tid,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [TID_W-1:0]  cmd_tid,
  input  logic [PW-1:0]     cmd_data,
  output logic              cmd_done,
  output logic              cmd_err,
  output logic              rsp_empty,
  output logic [TID_W-1:0]  rsp_src_tid,
  output logic [LEN_W-1:0]  rsp_len,
  output logic [PW-1:0]     rsp_data,
  output logic              irq,
  input  logic              tbl_wr_en,
  input  logic [XIDX_W-1:0] tbl_wr_idx,
  input  logic              tbl_wr_vld,
  input  logic [TID_W-1:0]  tbl_wr_tid,
  input  logic [CID_W-1:0]  tbl_wr_cid,
  output logic              net_tx_valid,
  input  logic              net_tx_ready,
  output logic [TAG_W-1:0]  net_tx_tag,
  output logic [CID_W-1:0]  net_tx_cid,
  output logic [TID_W-1:0]  net_tx_src_tid,
  output logic [LEN_W-1:0]  net_tx_len,
  output logic [PW-1:0]     net_tx_data,
  input  logic              net_ack_valid,
  input  logic [TAG_W-1:0]  net_ack_tag,
  input  logic              net_rx_valid,
  output logic              net_rx_ready,
  input  logic [TID_W-1:0]  net_rx_src_tid,
  input  logic [LEN_W-1:0]  net_rx_len,
  input  logic [PW-1:0]     net_rx_data
);
  localparam int SB_W = CID_W + LEN_W + PW;
  localparam int RX_W = TID_W + LEN_W + PW;

  cmd_op_e          op;
  logic             is_send, is_peek, is_recv, is_ien, is_idis, bad_op;
  logic             len_ok, xlt_hit, send_err, sb_alloc, sb_full;
  logic [CID_W-1:0] xlt_cid;
  logic [SB_W-1:0]  sb_pl;
  logic             rx_push, rx_pop, rxq_empty, rxq_full;
  logic [RX_W-1:0]  rx_head;
  logic             ien_q, ien_d, irq_q, irq_d;

  assign op      = cmd_op_e'(cmd_op);
  assign is_send = cmd_valid && op == OP_SEND;
  assign is_peek = cmd_valid && op == OP_PEEK;
  assign is_recv = cmd_valid && op == OP_RECV;
  assign is_ien  = cmd_valid && op == OP_IEN;
  assign is_idis = cmd_valid && op == OP_IDIS;
  assign bad_op  = cmd_valid && (cmd_op > 3'd4);
  assign len_ok  = (cmd_len <= LEN_W'(MAX_WORDS));

  msg_xlt #(.TID_W(TID_W), .CID_W(CID_W), .DEPTH(XLT_DEPTH)) xlt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tbl_wr_en),
    .wr_idx (tbl_wr_idx),
    .wr_vld (tbl_wr_vld),
    .wr_tid (tbl_wr_tid),
    .wr_cid (tbl_wr_cid),
    .lk_tid (cmd_tid),
    .lk_hit (xlt_hit),
    .lk_cid (xlt_cid)
  );

  assign send_err = is_send && !(xlt_hit && len_ok);
  assign sb_alloc = is_send && xlt_hit && len_ok && !sb_full;

  msg_sbuf #(.PW(SB_W), .DEPTH(SBUF_DEPTH)) sbuf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc     (sb_alloc),
    .alloc_pl  ({xlt_cid, cmd_len, cmd_data}),
    .full      (sb_full),
    .tx_valid  (net_tx_valid),
    .tx_ready  (net_tx_ready),
    .tx_tag    (net_tx_tag),
    .tx_pl     (sb_pl),
    .ack_valid (net_ack_valid),
    .ack_tag   (net_ack_tag)
  );

  assign {net_tx_cid, net_tx_len, net_tx_data} = sb_pl;
  assign net_tx_src_tid = self_tid;

  assign rx_push      = net_rx_valid && !rxq_full;
  assign rx_pop       = is_recv && !rxq_empty;
  assign net_rx_ready = !rxq_full;

  msg_fifo #(.W(RX_W), .DEPTH(RXQ_DEPTH)) rxq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .pop   (rx_pop),
    .wdata ({net_rx_src_tid, net_rx_len, net_rx_data}),
    .rdata (rx_head),
    .empty (rxq_empty),
    .full  (rxq_full)
  );

  assign {rsp_src_tid, rsp_len, rsp_data} = rx_head;
  assign rsp_empty = rxq_empty;

  assign cmd_done = send_err || sb_alloc || is_peek || rx_pop || is_ien || is_idis || bad_op;
  assign cmd_err  = send_err || bad_op;

  always_comb begin
    ien_d = ien_q;
    if (is_ien)  ien_d = 1'b1;
    if (is_idis) ien_d = 1'b0;
    irq_d = rx_push && ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ien_q <= ien_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(net_rx_valid && net_rx_ready && ien_q));
  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (net_rx_valid && net_rx_ready && ien_q) |=> irq);
  // R6
  recv_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2 && rsp_empty) |-> !cmd_done);
  // R2
  send_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0 && cmd_len > LEN_W'(MAX_WORDS)) |-> (cmd_done && cmd_err));
  // R5
  peek_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1) |-> (cmd_done && !cmd_err));
endmodule

// File: tb/msg_unit_tb_top.sv
`timescale 1ns/1ps
module msg_unit_tb_top;
  import msg_unit_pkg::*;
  localparam int TID_W = 8, CID_W = 6, DATA_W = 32, MW = 6, PW = MW * DATA_W;
  localparam int D = 16, TAG_W = 4, LEN_W = 3, XI_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [TID_W-1:0] self_tid;
  logic cmd_valid, cmd_done, cmd_err, rsp_empty, irq;
  logic [2:0] cmd_op;
  logic [LEN_W-1:0] cmd_len, rsp_len, net_tx_len, net_rx_len;
  logic [TID_W-1:0] cmd_tid, rsp_src_tid, net_tx_src_tid, net_rx_src_tid, tbl_wr_tid;
  logic [PW-1:0] cmd_data, rsp_data, net_tx_data, net_rx_data;
  logic tbl_wr_en, tbl_wr_vld, net_tx_valid, net_tx_ready, net_ack_valid, net_rx_valid, net_rx_ready;
  logic [XI_W-1:0] tbl_wr_idx;
  logic [CID_W-1:0] tbl_wr_cid, net_tx_cid;
  logic [TAG_W-1:0] net_tx_tag, net_ack_tag;

  msg_unit dut_i (.*);

  int checks = 0, errors = 0;
  logic [TID_W-1:0] rx_src_m [64];
  logic [LEN_W-1:0] rx_len_m [64];
  logic [PW-1:0]    rx_dat_m [64];
  int rx_rd = 0, rx_wr = 0;
  logic [TAG_W-1:0] ex_tag [64];
  logic [CID_W-1:0] ex_cid [64];
  logic [LEN_W-1:0] ex_len [64];
  logic [PW-1:0]    ex_dat [64];
  int ex_rd = 0, ex_wr = 0;
  logic [D-1:0] used_m = '0, sent_m = '0;
  bit ien_m = 0;
  bit map40 = 0;
  logic r_err, r_empty;
  logic [TID_W-1:0] r_src;
  logic [LEN_W-1:0] r_len;
  logic [PW-1:0] r_dat;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [TID_W-1:0] t);
    return (t >= 8'h10 && t <= 8'h17) || (t == 8'h40 && map40);
  endfunction
  function automatic logic [CID_W-1:0] cid_of(input logic [TID_W-1:0] t);
    return (t == 8'h40) ? 6'd9 : CID_W'(t - 8'h10 + 1);
  endfunction
  function automatic logic [TAG_W-1:0] lowest_free(input logic [D-1:0] u);
    for (int i = D - 1; i >= 0; i--) if (!u[i]) lowest_free = TAG_W'(i);
  endfunction
  function automatic bit data_eq(input logic [PW-1:0] a, input logic [PW-1:0] b, input int len);
    for (int i = 0; i < len; i++) if (a[i*DATA_W +: DATA_W] != b[i*DATA_W +: DATA_W]) return 0;
    return 1;
  endfunction
  function automatic logic [PW-1:0] rnd_data();
    for (int i = 0; i < MW; i++) rnd_data[i*DATA_W +: DATA_W] = $urandom;
  endfunction

  always @(negedge clk) begin
    if (rst_n && net_tx_valid && net_tx_ready) begin
      if (ex_rd == ex_wr) chk(0, "R2", "unexpected tx", net_tx_tag, 0);
      else begin
        chk(net_tx_tag == ex_tag[ex_rd % 64], "R4", "tx tag order", net_tx_tag, ex_tag[ex_rd % 64]);
        chk(net_tx_cid == ex_cid[ex_rd % 64], "R1", "tx core", net_tx_cid, ex_cid[ex_rd % 64]);
        chk(net_tx_len == ex_len[ex_rd % 64], "R1", "tx len", net_tx_len, ex_len[ex_rd % 64]);
        chk(data_eq(net_tx_data, ex_dat[ex_rd % 64], int'(net_tx_len)), "R1", "tx data w0",
            net_tx_data[31:0], ex_dat[ex_rd % 64][31:0]);
        chk(net_tx_src_tid == self_tid, "R1", "tx src", net_tx_src_tid, self_tid);
        sent_m[net_tx_tag] = 1'b1;
        ex_rd++;
      end
    end
  end

  task automatic do_cmd(input logic [2:0] op, input logic [LEN_W-1:0] len, input logic [TID_W-1:0] tid);
    logic [TAG_W-1:0] tg;
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_len = len; cmd_tid = tid;
    do @(negedge clk); while (!cmd_done);
    r_err = cmd_err; r_empty = rsp_empty; r_src = rsp_src_tid; r_len = rsp_len; r_dat = rsp_data;
    if (op == 3'd0 && !cmd_err) begin
      tg = lowest_free(used_m);
      used_m[tg] = 1'b1;
      ex_tag[ex_wr % 64] = tg; ex_cid[ex_wr % 64] = cid_of(tid);
      ex_len[ex_wr % 64] = len; ex_dat[ex_wr % 64] = cmd_data;
      ex_wr++;
    end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic send(input logic [TID_W-1:0] tid, input logic [LEN_W-1:0] len, input bit exp_err);
    cmd_data = rnd_data();
    do_cmd(3'd0, len, tid);
    chk(r_err == exp_err, exp_err ? "R2" : "R1", "send err flag", r_err, exp_err);
  endtask

  task automatic set_irq(input bit en);
    do_cmd(en ? 3'd3 : 3'd4, '0, '0);
    ien_m = en;
    chk(!r_err, "R8", "irq cmd err", r_err, 0);
  endtask

  task automatic model_rx_push();
    rx_src_m[rx_wr % 64] = net_rx_src_tid; rx_len_m[rx_wr % 64] = net_rx_len;
    rx_dat_m[rx_wr % 64] = net_rx_data; rx_wr++;
  endtask

  task automatic push_rx();
    bit ie;
    @(posedge clk); #1;
    net_rx_valid = 1'b1; net_rx_src_tid = TID_W'($urandom); net_rx_len = LEN_W'($urandom_range(0, MW));
    net_rx_data = rnd_data();
    do @(negedge clk); while (!net_rx_ready);
    ie = ien_m;
    @(posedge clk); #1;
    net_rx_valid = 1'b0;
    model_rx_push();
    @(negedge clk);
    chk(irq == ie, "R8", "irq after arrival", irq, ie);
    @(negedge clk);
    chk(irq == 1'b0, "R8", "irq one cycle", irq, 0);
  endtask

  task automatic check_head(input string req);
    chk(r_src == rx_src_m[rx_rd % 64], req, "head src", r_src, rx_src_m[rx_rd % 64]);
    chk(r_len == rx_len_m[rx_rd % 64], req, "head len", r_len, rx_len_m[rx_rd % 64]);
  endtask

  task automatic recv_chk();
    do_cmd(3'd2, '0, '0);
    check_head("R6");
    chk(data_eq(r_dat, rx_dat_m[rx_rd % 64], int'(r_len)), "R6", "recv data w0", r_dat[31:0], rx_dat_m[rx_rd % 64][31:0]);
    rx_rd++;
  endtask

  task automatic peek_chk();
    do_cmd(3'd1, '0, '0);
    chk(r_empty == (rx_rd == rx_wr), "R5", "peek empty", r_empty, rx_rd == rx_wr);
    if (rx_rd != rx_wr) check_head("R5");
  endtask

  task automatic ack(input logic [TAG_W-1:0] tg);
    @(posedge clk); #1;
    net_ack_valid = 1'b1; net_ack_tag = tg;
    @(posedge clk); #1;
    net_ack_valid = 1'b0;
    used_m[tg] = 1'b0; sent_m[tg] = 1'b0;
  endtask

  task automatic tbl_write(input int idx, input bit v, input logic [TID_W-1:0] t, input logic [CID_W-1:0] c);
    @(posedge clk); #1;
    tbl_wr_en = 1'b1; tbl_wr_idx = XI_W'(idx); tbl_wr_vld = v; tbl_wr_tid = t; tbl_wr_cid = c;
    @(posedge clk); #1;
    tbl_wr_en = 1'b0;
  endtask

  task automatic drain_and_ack();
    while (ex_rd != ex_wr) @(negedge clk);
    for (int i = 0; i < D; i++) if (used_m[i]) ack(TAG_W'(i));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    self_tid = 8'hA5; cmd_valid = 0; cmd_op = 0; cmd_len = 0; cmd_tid = 0; cmd_data = '0;
    tbl_wr_en = 0; tbl_wr_idx = 0; tbl_wr_vld = 0; tbl_wr_tid = 0; tbl_wr_cid = 0;
    net_tx_ready = 0; net_ack_valid = 0; net_ack_tag = 0;
    net_rx_valid = 0; net_rx_src_tid = 0; net_rx_len = 0; net_rx_data = '0;
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 0, "R9", "reset irq", irq, 0);
    chk(net_tx_valid == 0, "R9", "reset tx valid", net_tx_valid, 0);
    chk(net_rx_ready == 1, "R9", "reset rx ready", net_rx_ready, 1);
    chk(rsp_empty == 1, "R9", "reset empty", rsp_empty, 1);
    send(8'h11, 3'd1, 1'b1);
    peek_chk();

    for (int k = 0; k < 8; k++) tbl_write(k, 1'b1, TID_W'(8'h10 + k), CID_W'(k + 1));
    tbl_write(8, 1'b1, 8'h40, 6'd9);
    map40 = 1;

    // R4 hold while the network is not ready
    send(8'h13, 3'd4, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(net_tx_valid == 1 && net_tx_tag == 0, "R4", "tx held", {net_tx_valid, net_tx_tag}, 5'h10);
    end
    @(posedge clk); #1 net_tx_ready = 1'b1;
    send(8'h40, 3'd6, 1'b0);
    drain_and_ack();

    // R10 and R2 rejections
    tbl_write(8, 1'b0, 8'h40, 6'd9);
    map40 = 0;
    send(8'h40, 3'd2, 1'b1);
    send(8'h77, 3'd2, 1'b1);
    send(8'h12, 3'd7, 1'b1);
    do_cmd(3'd6, '0, '0);
    chk(r_err == 1, "R2", "bad op err", r_err, 1);
    @(negedge clk);
    chk(net_tx_valid == 0, "R2", "nothing queued", net_tx_valid, 0);
    send(8'h10, 3'd0, 1'b0);
    drain_and_ack();

    // R3 fill all entries, then a stalled send released by one ack
    for (int i = 0; i < D; i++) send(TID_W'(8'h10 + (i % 8)), LEN_W'($urandom_range(0, MW)), 1'b0);
    while (ex_rd != ex_wr) @(negedge clk);
    cmd_data = rnd_data();
    @(posedge clk); #1;
    cmd_valid = 1; cmd_op = 3'd0; cmd_len = 3'd2; cmd_tid = 8'h12;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cmd_done == 0, "R3", "send stalls on full", cmd_done, 0);
    end
    @(posedge clk); #1;
    net_ack_valid = 1; net_ack_tag = 4'd5;
    @(negedge clk);
    chk(cmd_done == 0, "R3", "still full before ack edge", cmd_done, 0);
    @(posedge clk); #1;
    net_ack_valid = 0; used_m[5] = 0; sent_m[5] = 0;
    @(negedge clk);
    chk(cmd_done == 1 && cmd_err == 0, "R3", "send after ack", {cmd_done, cmd_err}, 2'b10);
    used_m[5] = 1;
    ex_tag[ex_wr % 64] = 4'd5; ex_cid[ex_wr % 64] = cid_of(8'h12);
    ex_len[ex_wr % 64] = 3'd2; ex_dat[ex_wr % 64] = cmd_data; ex_wr++;
    @(posedge clk); #1 cmd_valid = 0;
    drain_and_ack();

    // R8 / R7 receive side
    set_irq(1);
    for (int i = 0; i < 5; i++) push_rx();
    set_irq(0);
    peek_chk();
    peek_chk();
    for (int i = 0; i < 11; i++) push_rx();
    @(negedge clk);
    chk(net_rx_ready == 0, "R7", "ready low when full", net_rx_ready, 0);
    @(posedge clk); #1;
    net_rx_valid = 1; net_rx_src_tid = 8'h3C; net_rx_len = 3'd6; net_rx_data = rnd_data();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(net_rx_ready == 0, "R7", "offered msg held", net_rx_ready, 0);
    end
    recv_chk();
    @(negedge clk);
    chk(net_rx_ready == 1, "R7", "ready after pop", net_rx_ready, 1);
    @(posedge clk); #1;
    net_rx_valid = 0;
    model_rx_push();
    @(negedge clk);
    chk(irq == 0, "R8", "no irq while disabled", irq, 0);
    while (rx_rd != rx_wr) recv_chk();
    peek_chk();

    // R6 receive on empty stalls until an arrival
    @(posedge clk); #1;
    cmd_valid = 1; cmd_op = 3'd2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cmd_done == 0, "R6", "recv stalls on empty", cmd_done, 0);
    end
    @(posedge clk); #1;
    net_rx_valid = 1; net_rx_src_tid = 8'h21; net_rx_len = 3'd3; net_rx_data = rnd_data();
    @(posedge clk); #1;
    net_rx_valid = 0;
    model_rx_push();
    @(negedge clk);
    chk(cmd_done == 1, "R6", "recv released", cmd_done, 1);
    r_src = rsp_src_tid; r_len = rsp_len;
    check_head("R6");
    rx_rd++;
    @(posedge clk); #1 cmd_valid = 0;

    // arrival and dequeue in the same cycle
    set_irq(1);
    for (int i = 0; i < 3; i++) push_rx();
    @(posedge clk); #1;
    cmd_valid = 1; cmd_op = 3'd2;
    net_rx_valid = 1; net_rx_src_tid = 8'h55; net_rx_len = 3'd5; net_rx_data = rnd_data();
    @(negedge clk);
    chk(cmd_done == 1, "R6", "recv with arrival", cmd_done, 1);
    r_src = rsp_src_tid; r_len = rsp_len;
    check_head("R6");
    rx_rd++;
    model_rx_push();
    @(posedge clk); #1;
    cmd_valid = 0; net_rx_valid = 0;
    @(negedge clk);
    chk(irq == 1, "R8", "irq on same-cycle arrival", irq, 1);
    for (int i = 0; i < 3; i++) recv_chk();
    peek_chk();

    // random mix
    for (int it = 0; it < 400; it++) begin
      int c;
      c = $urandom_range(0, 5);
      case (c)
        0: begin
          logic [TID_W-1:0] t;
          t = ($urandom_range(0, 9) == 0) ? 8'h77 : TID_W'(8'h10 + $urandom_range(0, 7));
          if (!mapped(t)) send(t, LEN_W'($urandom_range(0, MW)), 1'b1);
          else if ($countones(used_m) < D) send(t, LEN_W'($urandom_range(0, MW)), 1'b0);
        end
        1: if (sent_m != '0) begin
          int s;
          s = $urandom_range(0, D - 1);
          for (int j = 0; j < D; j++) if (sent_m[(s + j) % D]) begin ack(TAG_W'((s + j) % D)); break; end
        end
        2: if (rx_wr - rx_rd < D) push_rx();
        3: if (rx_wr != rx_rd) recv_chk();
        4: peek_chk();
        default: set_irq($urandom_range(0, 1) == 1);
      endcase
    end
    drain_and_ack();
    while (rx_rd != rx_wr) recv_chk();
    peek_chk();
    finish_run();
  end
endmodule